// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits after the error-correction stage of a broadcast demodulator. It takes decoded transport packets one byte at a time and drives them onto an external output port. The port carries an output clock, a data bus, a packet-start strobe, a data-valid strobe and an uncorrectable-packet flag. The port works as an 8-bit parallel bus or as a 1-bit serial line. Both the mode and the launching edge of the output clock are configuration inputs. They are held constant outside reset.

Upstream bytes arrive through a valid/ready handshake. The first byte of a packet is marked by a start flag, and an uncorrectable flag comes with it. The formatter keeps its own byte count, so every packet it emits is exactly 188 bytes long. It also checks each packet's first byte against the expected sync value and records a sticky error when the two differ.

The output clock runs at half the system clock rate. Data and strobes change only on the configured launching edge, so the receiver can capture them on the opposite edge.

Top module: `ts_fmt`

## Requirements
- R1: Every emitted packet has exactly 188 bytes. At a packet boundary, an accepted byte whose start flag is low is discarded, and nothing of it appears on the port. A start flag raised inside a packet is ignored.
- R2: `pSync` is high only while the first byte of a packet is on the port, and `dValid` is high whenever `pSync` is high.
- R3: `dValid` is low for every output clock period that carries no packet byte. During such a period `dOut` keeps its previous value.
- R4: `uncorOut` takes the value of `inUncor` sampled with a packet's first byte. It holds that value across every byte of the packet.
- R5: When `serMode` is 0, each packet byte is presented whole on `dOut[7:0]` for one output clock period.
- R6: When `serMode` is 1, each byte is sent most significant bit first on `dOut[0]` over 8 output clock periods. `dOut[7:1]` stays 0, and `pSync` and `dValid` hold their values for all 8 bit periods.
- R7: `outClk` has a period of two `clk` cycles. With `invEdge`=0, the outputs change only when `outClk` rises; with `invEdge`=1, they change only when it falls.
- R8: If a packet's first byte is not 0x47, `syncErr` is set and stays set until reset. The packet is still forwarded unchanged.
- R9: `inReady` is high only in the `clk` cycle before a launching edge, and never while a serial byte still has bits to send. A byte transfers at a `clk` edge where `inValid` and `inReady` are both high. So transfers are at least 2 `clk` cycles apart in parallel mode and at least 16 in serial mode.
- R10: While `rstN` is low, `outClk`, `dOut`, `pSync`, `dValid`, `uncorOut` and `syncErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serMode | input | 1 | 1 selects serial output on bit 0; 0 selects the parallel bus |
| invEdge | input | 1 | 1 launches outputs on the falling edge of `outClk` |
| inData | input | 8 | Upstream byte |
| inValid | input | 1 | Upstream byte is available |
| inSop | input | 1 | Upstream byte is the first byte of a packet |
| inUncor | input | 1 | The packet starting with this byte could not be corrected |
| inReady | output | 1 | Formatter accepts a byte at this clock edge |
| outClk | output | 1 | Output clock, half the `clk` rate |
| dOut | output | 8 | Output data bus (serial uses bit 0) |
| pSync | output | 1 | First byte of a packet is on the port |
| dValid | output | 1 | A packet byte is on the port |
| uncorOut | output | 1 | The current packet is uncorrectable |
| syncErr | output | 1 | Sticky: some packet began with a byte other than 0x47 |

## Verification
The bench targets packet framing. It sends junk bytes before a start flag and raises a stray start flag in mid-packet. A formatter that trusted the upstream marker would emit short or long packets, or pulse `pSync` twice.

It also inserts gaps in the middle of packets. A design that let `dValid` stick high during a gap would duplicate bytes, and one that cleared the bus would break the hold check.

Serial runs check the bit order, the quiet upper bits and the 16-cycle spacing of the handshake. Swapping the bit order or allowing a new byte in during shifting corrupts the captured bytes.

Runs with the inverted launch edge and with a bad sync byte check that outputs never move on the capture edge, and that the error flag stays set into the next good packet.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  // Strobes from the control path to the datapath, valid for one clk cycle.
  typedef struct packed {
    logic load;   // put a new packet byte on the port
    logic first;  // the byte being loaded is a packet's first byte
    logic shift;  // send the next serial bit of the current byte
    logic idle;   // launching slot with no packet byte
  } fmtStrb_t;
endpackage

// File: rtl/ts_fmt_ctrl.sv
module ts_fmt_ctrl
  import ts_fmt_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int DATA_W  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serMode,
  input  logic     invEdge,
  input  logic     inValid,
  input  logic     inSop,
  output logic     inReady,
  output logic     outClk,
  output fmtStrb_t strb
);
  localparam int CNT_W = $clog2(PKT_LEN);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic             phase;
  logic             launch;
  logic [BIT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] byteIdx;
  logic             busy;
  logic             take;
  logic             atStart;
  logic             emit;

  // The edge at the end of this cycle is the launching edge of outClk.
  assign launch  = invEdge ? phase : ~phase;
  assign busy    = serMode && (bitsLeft != '0);
  assign inReady = launch && !busy;
  assign take    = inReady && inValid;
  assign atStart = (byteIdx == '0);
  assign emit    = take && (!atStart || inSop);
  assign outClk  = phase;

  always_comb begin
    strb.load  = emit;
    strb.first = atStart;
    strb.shift = launch && busy;
    strb.idle  = launch && !busy && !emit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      byteIdx  <= '0;
      bitsLeft <= '0;
    end else begin
      phase <= ~phase;
      if (emit) byteIdx <= (byteIdx == LAST_IDX) ? '0 : byteIdx + 1'b1;
      if (emit && serMode) bitsLeft <= LAST_BIT;
      else if (launch && busy) bitsLeft <= bitsLeft - 1'b1;
    end
  end

  // R1
  byte_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= LAST_IDX);

  // R9
  ready_serial_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emit && serMode) |=> ##1 !inReady);
endmodule

// File: rtl/ts_fmt_data.sv
module ts_fmt_data
  import ts_fmt_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'h47
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serMode,
  input  fmtStrb_t          strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inUncor,
  output logic [DATA_W-1:0] dOut,
  output logic              pSync,
  output logic              dValid,
  output logic              uncorOut,
  output logic              syncErr
);
  localparam logic [DATA_W-2:0] HI_ZERO = '0;

  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut     <= '0;
      shReg    <= '0;
      pSync    <= 1'b0;
      dValid   <= 1'b0;
      uncorOut <= 1'b0;
      syncErr  <= 1'b0;
    end else if (strb.load) begin
      dValid <= 1'b1;
      pSync  <= strb.first;
      if (strb.first) begin
        uncorOut <= inUncor;
        if (inData != SYNC_BYTE) syncErr <= 1'b1;
      end
      if (serMode) begin
        dOut  <= {HI_ZERO, inData[DATA_W-1]};
        shReg <= {inData[DATA_W-2:0], 1'b0};
      end else begin
        dOut <= inData;
      end
    end else if (strb.shift) begin
      dOut  <= {HI_ZERO, shReg[DATA_W-1]};
      shReg <= {shReg[DATA_W-2:0], 1'b0};
    end else if (strb.idle) begin
      dValid <= 1'b0;
      pSync  <= 1'b0;
    end
  end

  // R8
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> syncErr);

  // R4
  uncor_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.first) |=> $stable(uncorOut));

  // R6
  serial_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> ($stable(dValid) && $stable(pSync)));
endmodule

// File: rtl/ts_fmt.sv
module ts_fmt
  import ts_fmt_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serMode,
  input  logic              invEdge,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inUncor,
  output logic              inReady,
  output logic              outClk,
  output logic [DATA_W-1:0] dOut,
  output logic              pSync,
  output logic              dValid,
  output logic              uncorOut,
  output logic              syncErr
);
  fmtStrb_t strb;

  ts_fmt_ctrl #(.PKT_LEN(PKT_LEN), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .serMode(serMode), .invEdge(invEdge),
    .inValid(inValid), .inSop(inSop), .inReady(inReady),
    .outClk(outClk), .strb(strb)
  );

  ts_fmt_data #(.DATA_W(DATA_W), .SYNC_BYTE(DATA_W'(8'h47))) u_data (
    .clk(clk), .rstN(rstN), .serMode(serMode), .strb(strb),
    .inData(inData), .inUncor(inUncor), .dOut(dOut), .pSync(pSync),
    .dValid(dValid), .uncorOut(uncorOut), .syncErr(syncErr)
  );

  // R2
  sync_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pSync |-> dValid);

  // R6
  serial_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    serMode |-> (dOut[DATA_W-1:1] == '0));

  // R7
  capture_edge_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invEdge ? !outClk : outClk) |=>
      ($stable(dOut) && $stable(pSync) && $stable(dValid) && $stable(uncorOut)));
endmodule

// File: tb/test_ts_fmt.sv
module test_ts_fmt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serMode = 1'b0, invEdge = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inSop = 1'b0, inUncor = 1'b0;
  logic inReady, outClk, pSync, dValid, uncorOut, syncErr;
  logic [7:0] dOut;

  ts_fmt i_ts_fmt (
    .clk(clk), .rstN(rstN), .serMode(serMode), .invEdge(invEdge),
    .inData(inData), .inValid(inValid), .inSop(inSop), .inUncor(inUncor),
    .inReady(inReady), .outClk(outClk), .dOut(dOut), .pSync(pSync),
    .dValid(dValid), .uncorOut(uncorOut), .syncErr(syncErr)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // expected stream
  logic [7:0] expB [0:1023];
  logic       expS [0:1023];
  logic       expU [0:1023];
  int expN;
  // captured stream
  logic [7:0] capB [0:1023];
  logic       capS [0:1023];
  logic       capU [0:1023];
  int capN;

  logic monOn = 1'b0;
  logic [10:0] snap;
  logic [7:0] lastD;
  int edgeErr, holdErr, serErr, syncMis;
  int sBits;
  logic [7:0] sAcc;
  logic sS, sU;
  int lastXfer, minGap;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor: snapshot at launch edge, capture at the opposite edge
  always @(outClk) begin
    #1;
    if (monOn) begin
      if (outClk == !invEdge) begin
        snap = {dOut, pSync, dValid, uncorOut};
      end else begin
        if ({dOut, pSync, dValid, uncorOut} != snap) edgeErr++;
        if (serMode && dOut[7:1] != 7'd0) serErr++;
        if (dValid) begin
          if (!serMode) begin
            if (capN < 1024) begin
              capB[capN] = dOut; capS[capN] = pSync; capU[capN] = uncorOut;
            end
            capN++;
          end else begin
            if (sBits == 0) begin sS = pSync; sU = uncorOut; end
            else if (pSync != sS) syncMis++;
            sAcc = {sAcc[6:0], dOut[0]};
            sBits++;
            if (sBits == 8) begin
              if (capN < 1024) begin
                capB[capN] = sAcc; capS[capN] = sS; capU[capN] = sU;
              end
              capN++;
              sBits = 0;
            end
          end
        end else if (dOut != lastD) begin
          holdErr++;
        end
        lastD = dOut;
      end
    end
  end

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic doReset(input logic ser, input logic inv);
    monOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    serMode = ser; invEdge = inv;
    inValid = 1'b0; inSop = 1'b0; inUncor = 1'b0; inData = '0;
    repeat (3) @(negedge clk);
    snap = '0; lastD = '0;
    edgeErr = 0; holdErr = 0; serErr = 0; syncMis = 0; sBits = 0; sAcc = '0;
    expN = 0; capN = 0; lastXfer = -1000; minGap = 100000;
    rstN = 1'b1;
    monOn = 1'b1;
  endtask

  task automatic putByte(input logic [7:0] b, input logic sop, input logic unc);
    @(negedge clk);
    inData = b; inSop = sop; inUncor = unc; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    if (cyc - lastXfer < minGap) minGap = cyc - lastXfer;
    lastXfer = cyc;
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0;
  endtask

  task automatic sendPkt(input int p, input logic unc, input logic [7:0] firstB,
                         input bit midSop);
    for (int i = 0; i < 188; i++) begin
      logic [7:0] b;
      b = (i == 0) ? firstB : pat(p, i);
      putByte(b, (i == 0) || (midSop && i == 50), unc);
      expB[expN] = b; expS[expN] = (i == 0); expU[expN] = unc; expN++;
      if (i % 7 == 3) repeat (3) @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic compareAll(input string req);
    int dErr, sErr, uErr;
    dErr = 0; sErr = 0; uErr = 0;
    chk(capN == expN, req, "byte count", capN, expN);
    for (int k = 0; k < expN && k < capN; k++) begin
      if (capB[k] != expB[k]) dErr++;
      if (capS[k] != expS[k]) sErr++;
      if (capU[k] != expU[k]) uErr++;
    end
    chk(dErr == 0, req, "data byte mismatches", dErr, 0);
    chk(sErr == 0, {req, " R2"}, "pSync mismatches", sErr, 0);
    chk(uErr == 0, {req, " R4"}, "uncorOut mismatches", uErr, 0);
    chk(edgeErr == 0, "R7", "outputs moved on capture edge", edgeErr, 0);
    chk(holdErr == 0, "R3", "bus changed during gap", holdErr, 0);
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    // R10
    chk({outClk, dOut, pSync, dValid, uncorOut, syncErr} == 13'd0, "R10",
        "outputs in reset", int'({outClk, dOut, pSync, dValid, uncorOut, syncErr}), 0);
  endtask

  task automatic testParallel();
    doReset(1'b0, 1'b0);
    sendPkt(1, 1'b0, 8'h47, 1'b0);
    sendPkt(2, 1'b1, 8'h47, 1'b0);
    drain();
    compareAll("R5");
    chk(syncErr == 1'b0, "R8", "syncErr on good packets", syncErr, 0);
    chk(minGap == 2, "R9", "parallel min transfer gap", minGap, 2);
  endtask

  task automatic testFraming();
    doReset(1'b0, 1'b0);
    for (int j = 0; j < 5; j++) putByte(8'h47, 1'b0, 1'b1); // R1 dropped
    sendPkt(3, 1'b0, 8'h47, 1'b1);
    drain();
    compareAll("R1");
  endtask

  task automatic testSyncErr();
    doReset(1'b0, 1'b0);
    sendPkt(4, 1'b0, 8'h12, 1'b0);
    drain();
    chk(syncErr == 1'b1, "R8", "syncErr after bad first byte", syncErr, 1);
    sendPkt(5, 1'b1, 8'h47, 1'b0);
    drain();
    chk(syncErr == 1'b1, "R8", "syncErr sticky", syncErr, 1);
    compareAll("R8");
  endtask

  task automatic testSerial();
    doReset(1'b1, 1'b0);
    sendPkt(6, 1'b1, 8'h47, 1'b0);
    sendPkt(7, 1'b0, 8'h47, 1'b0);
    drain();
    compareAll("R6");
    chk(serErr == 0, "R6", "upper bits nonzero in serial", serErr, 0);
    chk(syncMis == 0, "R6", "pSync changed within serial byte", syncMis, 0);
    chk(minGap == 16, "R9", "serial min transfer gap", minGap, 16);
  endtask

  task automatic testInvert();
    doReset(1'b0, 1'b1);
    sendPkt(8, 1'b1, 8'h47, 1'b0);
    drain();
    compareAll("R7");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testParallel();
    testFraming();
    testSyncErr();
    testSerial();
    testInvert();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule